// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a bus master read an external serial NOR flash as if it were memory. The master presents a read request with a byte address and a chip-select index. The engine then runs one complete flash read frame without any software sequencing: it selects the flash, sends a read opcode and an address, waits out a number of dummy cycles, and collects four data bytes. It returns them as one 32-bit word and deselects the flash.

The whole frame is built from one packed setup word. That word holds the opcode, the address length, the dummy bytes, an extra dummy-bit count and the width of the data phase (one, two or four lines). A separate mode switch decides whether memory-mapped reads are allowed at all. When the switch is off, the flash pins are left to a register-command engine outside this block.

The serial clock runs at half the system clock and is idle low (SPI mode 0). The opcode, address and dummy phases always use line 0. Only the data phase fans out to two or four lines.

Top module: `sflash_mmap_rd`

## Requirements
- R1: After reset all chip selects are high, the serial clock is low, every line output enable is low, rdReady is low, and the mode switch and setup word are cleared.
- R2: With switch bit 0 cleared (cfgSel=1 write), an accepted read answers on the first clock edge with rdReady=1, rdErr=1 and rdData=0, and no chip select or serial clock activity occurs.
- R3: A setup word written as all zeros disables reads: with the switch set, a read still answers as in R2.
- R4: A frame starts with setup bits 7:0 (the opcode) and then the low N bytes of rdAddr, where N is setup bits 9:8 (0 to 3). Both go out most significant bit first on ioOut[0], one bit per serial clock.
- R5: After the address, the engine adds 8×(setup bits 11:10) plus (setup bits 28:24) dummy clocks, during which ioOut[0] is driven low.
- R6: Setup bits 13:12 set the data phase. A value of 1 uses ioIn[1:0], 3 uses ioIn[3:0], and 0 or 2 uses ioIn[1] alone. The higher-numbered line carries the more significant bit, and each byte arrives most significant part first.
- R7: The four data bytes are packed little-endian: the first byte received lands in rdData[7:0] and the fourth in rdData[31:24].
- R8: From acceptance until the response, exactly csN[csIdx] is low (active low). All chip selects are high again in the cycle rdReady is high.
- R9: rdReady is a one-cycle pulse. Count clock edges from the one that accepts the read, which counts as edge 1. A normal read answers on edge 2×(H+D)+2, where H = 8+8·N+8·dummyBytes+dummyBits and D = 32/lanes.
- R10: ioOe[0] is high through the opcode, address and dummy clocks and low in the data phase. ioOe[3:1] are never high.
- R11: Each serial clock is one system cycle low followed by one system cycle high. Input is captured as it rises, and a frame gives exactly H+D rising edges.
- R12: A setup write made while a read is in progress does not change that read. It applies from the next read onward.
- R13: Setup bits 23:16 (the write opcode) have no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the setup word, 1 the mode switch |
| cfgWdata | input | 32 | Configuration write data |
| rdValid | input | 1 | Read request, held until rdReady |
| rdAddr | input | ADDR_W | Flash byte address of the read |
| csIdx | input | CS_W | Chip select used for the read |
| rdReady | output | 1 | One-cycle response strobe |
| rdData | output | 32 | Returned word, valid with rdReady |
| rdErr | output | 1 | Read refused (switch off or setup zero) |
| csN | output | NUM_CS | Active-low chip selects |
| sclk | output | 1 | Serial clock, idle low |
| ioOut | output | 4 | Flash line output values |
| ioOe | output | 4 | Flash line output enables |
| ioIn | input | 4 | Flash line input values |

## Verification
The bench keeps the default NUM_CS=4 and ADDR_W=24. With these values every chip-select index, full 3-byte addresses and the longest header of 87 clocks (3 address bytes, 3 dummy bytes, 31 dummy bits) are all in range. A flash model in the bench puts a different known byte pattern on the unused lines. Because of that, a wrong lane choice or lane order shows up as a wrong word. A setup write placed in the middle of a frame tests the snapshot taken at acceptance.

// File: rtl/sfm_pkg.sv
`timescale 1ns/1ps
package sfm_pkg;
  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef struct packed {
    logic  load;
    logic  shiftOut;
    logic  capture;
    lane_e capLanes;
    logic  retData;
    logic  retErr;
  } dpStrobe_t;

  localparam int HDR_W  = 7;
  localparam int DCNT_W = 5;
  localparam int SH_W   = 32;
endpackage

// File: rtl/sfm_cfg.sv
`timescale 1ns/1ps
module sfm_cfg
  import sfm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic        cfgSel,
  input  logic [31:0] cfgWdata,
  output logic [7:0]  opcode,
  output logic [1:0]  addrBytes,
  output logic [1:0]  dummyBytes,
  output logic [4:0]  dummyBits,
  output lane_e       lanes,
  output logic        mmapOn
);
  logic [13:0] setupLo;
  logic [4:0]  dBitsR;
  logic        setupNz;
  logic        switchOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupLo  <= '0;
      dBitsR   <= '0;
      setupNz  <= 1'b0;
      switchOn <= 1'b0;
    end else if (cfgWe) begin
      if (cfgSel) begin
        switchOn <= cfgWdata[0];
      end else begin
        setupLo <= cfgWdata[13:0];
        dBitsR  <= cfgWdata[28:24];
        setupNz <= |cfgWdata;
      end
    end
  end

  assign opcode     = setupLo[7:0];
  assign addrBytes  = setupLo[9:8];
  assign dummyBytes = setupLo[11:10];
  assign dummyBits  = dBitsR;
  assign mmapOn     = switchOn & setupNz;

  always_comb begin
    case (setupLo[13:12])
      2'd1:    lanes = LANE_X2;
      2'd3:    lanes = LANE_X4;
      default: lanes = LANE_X1;
    endcase
  end
endmodule

// File: rtl/sfm_ctrl.sv
`timescale 1ns/1ps
module sfm_ctrl
  import sfm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [CS_W-1:0]   csIdx,
  input  logic              mmapOn,
  input  logic [1:0]        addrBytes,
  input  logic [1:0]        dummyBytes,
  input  logic [4:0]        dummyBits,
  input  lane_e             lanes,
  output logic              rdReady,
  output logic              rdErr,
  output logic [NUM_CS-1:0] csN,
  output logic              sclk,
  output logic [3:0]        ioOe,
  output dpStrobe_t         stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA, ST_FIN} state_e;

  state_e             state;
  logic               ph;
  logic [HDR_W-1:0]   cnt;
  logic [HDR_W-1:0]   hdrLast;
  logic [DCNT_W-1:0]  dataLast;
  lane_e              lanesR;
  logic               oeR;
  logic [HDR_W-1:0]   hdrBits;
  logic [DCNT_W-1:0]  dataLastNew;
  logic               accept;

  assign hdrBits = HDR_W'(8) + HDR_W'({addrBytes, 3'b000})
                 + HDR_W'({dummyBytes, 3'b000}) + HDR_W'(dummyBits);

  always_comb begin
    case (lanes)
      LANE_X2: dataLastNew = DCNT_W'(15);
      LANE_X4: dataLastNew = DCNT_W'(7);
      default: dataLastNew = DCNT_W'(31);
    endcase
  end

  assign accept = (state == ST_IDLE) && rdValid && !rdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ph       <= 1'b0;
      cnt      <= '0;
      hdrLast  <= '0;
      dataLast <= '0;
      lanesR   <= LANE_X1;
      oeR      <= 1'b0;
      sclk     <= 1'b0;
      csN      <= '1;
      rdReady  <= 1'b0;
      rdErr    <= 1'b0;
    end else begin
      rdReady <= 1'b0;
      rdErr   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!mmapOn) begin
              rdReady <= 1'b1;
              rdErr   <= 1'b1;
            end else begin
              state    <= ST_HDR;
              csN      <= ~(NUM_CS'(1) << csIdx);
              cnt      <= '0;
              ph       <= 1'b0;
              hdrLast  <= hdrBits - HDR_W'(1);
              dataLast <= dataLastNew;
              lanesR   <= lanes;
              oeR      <= 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (!ph) begin
            sclk <= 1'b1;
            ph   <= 1'b1;
          end else begin
            sclk <= 1'b0;
            ph   <= 1'b0;
            if (cnt == hdrLast) begin
              state <= ST_DATA;
              cnt   <= '0;
              oeR   <= 1'b0;
            end else begin
              cnt <= cnt + HDR_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (!ph) begin
            sclk <= 1'b1;
            ph   <= 1'b1;
          end else begin
            sclk <= 1'b0;
            ph   <= 1'b0;
            if (cnt[DCNT_W-1:0] == dataLast) begin
              state <= ST_FIN;
            end
            cnt <= cnt + HDR_W'(1);
          end
        end
        default: begin
          state   <= ST_IDLE;
          csN     <= '1;
          rdReady <= 1'b1;
        end
      endcase
    end
  end

  assign ioOe = {3'b000, oeR};

  always_comb begin
    stb          = '0;
    stb.load     = accept && mmapOn;
    stb.retErr   = accept && !mmapOn;
    stb.shiftOut = (state == ST_HDR) && ph;
    stb.capture  = (state == ST_DATA) && !ph;
    stb.capLanes = lanesR;
    stb.retData  = (state == ST_FIN);
  end
endmodule

// File: rtl/sfm_dp.sv
`timescale 1ns/1ps
module sfm_dp
  import sfm_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        opcode,
  input  logic [1:0]        addrBytes,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [31:0]       rdData
);
  logic [SH_W-1:0] sh;
  logic [31:0]     capt;
  logic [23:0]     a24;
  logic [SH_W-1:0] hdrWord;

  assign a24 = 24'(rdAddr);

  always_comb begin
    case (addrBytes)
      2'd3:    hdrWord = {opcode, a24};
      2'd2:    hdrWord = {opcode, a24[15:0], 8'h00};
      2'd1:    hdrWord = {opcode, a24[7:0], 16'h0000};
      default: hdrWord = {opcode, 24'h000000};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh     <= '0;
      capt   <= '0;
      rdData <= '0;
    end else begin
      if (stb.load) begin
        sh <= hdrWord;
      end else if (stb.shiftOut) begin
        sh <= {sh[SH_W-2:0], 1'b0};
      end
      if (stb.capture) begin
        case (stb.capLanes)
          LANE_X2: capt <= {capt[29:0], ioIn[1:0]};
          LANE_X4: capt <= {capt[27:0], ioIn};
          default: capt <= {capt[30:0], ioIn[1]};
        endcase
      end
      if (stb.retData) begin
        rdData <= {capt[7:0], capt[15:8], capt[23:16], capt[31:24]};
      end else if (stb.retErr) begin
        rdData <= '0;
      end
    end
  end

  assign ioOut = {3'b000, sh[SH_W-1]};
endmodule

// File: rtl/sflash_mmap_rd.sv
`timescale 1ns/1ps
module sflash_mmap_rd
  import sfm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [31:0]       cfgWdata,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CS_W-1:0]   csIdx,
  output logic              rdReady,
  output logic [31:0]       rdData,
  output logic              rdErr,
  output logic [NUM_CS-1:0] csN,
  output logic              sclk,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  input  logic [3:0]        ioIn
);
  logic [7:0] opcode;
  logic [1:0] addrBytes;
  logic [1:0] dummyBytes;
  logic [4:0] dummyBits;
  lane_e      lanes;
  logic       mmapOn;
  dpStrobe_t  stb;

  sfm_cfg cfg_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .opcode(opcode), .addrBytes(addrBytes),
    .dummyBytes(dummyBytes), .dummyBits(dummyBits), .lanes(lanes),
    .mmapOn(mmapOn)
  );

  sfm_ctrl #(.NUM_CS(NUM_CS), .CS_W(CS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .csIdx(csIdx),
    .mmapOn(mmapOn), .addrBytes(addrBytes), .dummyBytes(dummyBytes),
    .dummyBits(dummyBits), .lanes(lanes), .rdReady(rdReady),
    .rdErr(rdErr), .csN(csN), .sclk(sclk), .ioOe(ioOe), .stb(stb)
  );

  sfm_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .opcode(opcode),
    .addrBytes(addrBytes), .rdAddr(rdAddr), .ioIn(ioIn),
    .ioOut(ioOut), .rdData(rdData)
  );
endmodule

// File: rtl/sflash_mmap_rd_chk.sv
`timescale 1ns/1ps
module sflash_mmap_rd_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReady,
  input logic              rdErr,
  input logic [31:0]       rdData,
  input logic [NUM_CS-1:0] csN,
  input logic              sclk,
  input logic [3:0]        ioOe
);
  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> rdReady); // R2
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (rdData == 32'h0)); // R3
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> !rdReady); // R9
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1); // R8
  AST_CS_FREE_AT_RESP: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> (&csN)); // R8
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> !sclk); // R11
  AST_SCLK_HIGH_ONE: assert property (@(posedge clk) disable iff (!rstN)
    sclk |=> !sclk); // R11
  AST_UPPER_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ioOe[3:1] == 3'b000); // R10
  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    ioOe[0] |-> !(&csN)); // R10
endmodule

bind sflash_mmap_rd sflash_mmap_rd_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rstN(rstN), .rdReady(rdReady), .rdErr(rdErr),
  .rdData(rdData), .csN(csN), .sclk(sclk), .ioOe(ioOe)
);

// File: tb/sflash_mmap_rd_tb_top.sv
`timescale 1ns/1ps
module sflash_mmap_rd_tb_top;
  localparam int NUM_CS = 4;
  localparam int ADDR_W = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic        rdValid = 1'b0;
  logic [23:0] rdAddr = '0;
  logic [1:0]  csIdx = '0;
  logic        rdReady;
  logic [31:0] rdData;
  logic        rdErr;
  logic [3:0]  csN;
  logic        sclk;
  logic [3:0]  ioOut;
  logic [3:0]  ioOe;
  logic [3:0]  ioIn;

  int errors = 0;
  int checks = 0;

  // flash model state
  int           edgeCnt = 0;
  int           mHdr = 8;
  int           mLanes = 1;
  logic [31:0]  mStream = '0;
  logic [127:0] hdrCap = '0;
  logic [3:0]   expCs = 4'hF;
  int           csViol = 0;
  int           oeViol = 0;
  logic         sclkQ = 1'b0;
  logic [31:0]  curSetup = '0;

  always #2.5 clk = ~clk;

  sflash_mmap_rd #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .rdValid(rdValid), .rdAddr(rdAddr),
    .csIdx(csIdx), .rdReady(rdReady), .rdData(rdData), .rdErr(rdErr),
    .csN(csN), .sclk(sclk), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  // rising serial clock seen one system cycle later; frame state is held then
  always @(posedge clk) begin
    if (&csN) begin
      edgeCnt = 0;
      hdrCap  = '0;
    end else if (sclk && !sclkQ) begin
      if (csN != expCs) csViol++;
      if (edgeCnt < mHdr) begin
        hdrCap = {hdrCap[126:0], ioOut[0]};
        if (ioOe != 4'b0001) oeViol++;
      end else if (ioOe != 4'b0000) begin
        oeViol++;
      end
      edgeCnt++;
    end
    sclkQ = sclk;
  end

  always_comb begin
    int j;
    logic b;
    logic [1:0] d;
    ioIn = 4'b1010;
    j = edgeCnt - mHdr;
    if (j >= 0 && j * mLanes < 32) begin
      if (mLanes == 4) begin
        ioIn = mStream[31 - 4*j -: 4];
      end else if (mLanes == 2) begin
        d = mStream[31 - 2*j -: 2];
        ioIn = {~d, d};
      end else begin
        b = mStream[31 - j];
        ioIn = {~b, ~b, b, ~b};
      end
    end
  end

  function automatic int hdrLen(input logic [31:0] s);
    return 8 + 8 * int'(s[9:8]) + 8 * int'(s[11:10]) + int'(s[28:24]);
  endfunction

  function automatic int lanesOf(input logic [31:0] s);
    if (s[13:12] == 2'd1) return 2;
    if (s[13:12] == 2'd3) return 4;
    return 1;
  endfunction

  function automatic logic [7:0] flashByte(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [127:0] expHdr(input logic [31:0] s, input logic [23:0] a);
    logic [127:0] v;
    int na;
    na = int'(s[9:8]);
    v = 128'(s[7:0]);
    for (int i = na - 1; i >= 0; i--) v = (v << 8) | 128'(a[8*i +: 8]);
    v = v << (8 * int'(s[11:10]) + int'(s[28:24]));
    return v;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (!sel) curSetup = d;
  endtask

  task automatic doRead(input logic [31:0] s, input logic [23:0] a, input int cs,
                        input string tag, input bit useSetup);
    int lat;
    bit expErr;
    logic [31:0] expData;
    expErr  = !useSetup || (s == 32'h0);
    mHdr    = hdrLen(s);
    mLanes  = lanesOf(s);
    mStream = {flashByte(a), flashByte(a + 24'd1), flashByte(a + 24'd2), flashByte(a + 24'd3)};
    expData = {flashByte(a + 24'd3), flashByte(a + 24'd2), flashByte(a + 24'd1), flashByte(a)};
    expCs   = ~(4'b0001 << cs);
    csViol  = 0;
    oeViol  = 0;
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a; csIdx = 2'(cs);
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (rdReady || lat > 1000) break;
    end
    rdValid = 1'b0;
    if (expErr) begin
      chk({tag, " R2 err flag"}, 128'(rdErr), 128'(1));
      chk({tag, " R3 err data"}, 128'(rdData), 128'(0));
      chk({tag, " R2 err latency"}, 128'(lat), 128'(1));
      chk({tag, " R2 no serial clocks"}, 128'(edgeCnt), 128'(0));
    end else begin
      chk({tag, " R7 data word"}, 128'(rdData), 128'(expData));
      chk({tag, " R2 no err"}, 128'(rdErr), 128'(0));
      chk({tag, " R9 latency"}, 128'(lat), 128'(2 * (mHdr + 32 / mLanes) + 2));
      chk({tag, " R4 R5 header bits"}, hdrCap, expHdr(s, a));
      chk({tag, " R11 rising edges"}, 128'(edgeCnt), 128'(mHdr + 32 / mLanes));
      chk({tag, " R8 chip select"}, 128'(csViol), 128'(0));
      chk({tag, " R10 output enable"}, 128'(oeViol), 128'(0));
    end
    chk({tag, " R8 released"}, 128'(csN), 128'(4'hF));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [31:0] sQuad;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 csN", 128'(csN), 128'(4'hF));
    chk("R1 sclk", 128'(sclk), 128'(0));
    chk("R1 ioOe", 128'(ioOe), 128'(0));
    chk("R1 rdReady", 128'(rdReady), 128'(0));
    rstN = 1'b1;
    @(negedge clk);

    // R1 switch and setup cleared: read refused
    doRead(32'h0, 24'h000100, 0, "R1 post-reset read", 1'b0);

    // R2 switch off with a valid setup
    cfgWrite(1'b0, 32'h0012_0303);
    doRead(curSetup, 24'h123456, 1, "R2 switch off", 1'b0);

    // R3 switch on, setup zero
    cfgWrite(1'b1, 32'h1);
    cfgWrite(1'b0, 32'h0);
    doRead(curSetup, 24'h123456, 1, "R3 setup zero", 1'b1);

    // R4 normal single read, 3 address bytes
    cfgWrite(1'b0, 32'h0012_0303);
    doRead(curSetup, 24'hA5C3F0, 2, "R4 single read", 1'b1);

    // R5 fast read with one dummy byte
    cfgWrite(1'b0, 32'h0012_070B);
    doRead(curSetup, 24'h00FF10, 3, "R5 fast read", 1'b1);

    // R6 dual data
    cfgWrite(1'b0, 32'h0012_176B);
    doRead(curSetup, 24'h7E8001, 0, "R6 dual read", 1'b1);

    // R6 quad data
    cfgWrite(1'b0, 32'h0012_376C);
    doRead(curSetup, 24'h3C0FF3, 1, "R6 quad read", 1'b1);

    // R6 code 2 behaves as single
    cfgWrite(1'b0, 32'h0012_2303);
    doRead(curSetup, 24'h010203, 2, "R6 mode two single", 1'b1);

    // R5 dummy bits with one address byte, then no address
    cfgWrite(1'b0, 32'h0512_0177);
    doRead(curSetup, 24'hABCDEF, 3, "R5 dummy bits one addr", 1'b1);
    cfgWrite(1'b0, 32'h1F12_0C9F);
    doRead(curSetup, 24'h000042, 0, "R4 no addr max dummy", 1'b1);

    // R13 write opcode changed, same read otherwise
    cfgWrite(1'b0, 32'h00ED_0303);
    doRead(curSetup, 24'hA5C3F0, 2, "R13 write opcode ignored", 1'b1);

    // R12 setup write in the middle of a read
    s = 32'h0012_0303;
    sQuad = 32'h0012_376C;
    cfgWrite(1'b0, s);
    fork
      doRead(s, 24'h456789, 1, "R12 mid-read old setup", 1'b1);
      begin
        repeat (20) @(negedge clk);
        cfgWrite(1'b0, sQuad);
      end
    join
    doRead(sQuad, 24'h456789, 1, "R12 next read new setup", 1'b1);

    // constrained random reads
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      r = $urandom;
      r[31:29] = 3'b000;
      cfgWrite(1'b0, r);
      doRead(curSetup, 24'($urandom), int'($urandom % 4), "R6 random read", 1'b1);
    end

    // R2 switch cleared again
    cfgWrite(1'b0, 32'h0012_0303);
    cfgWrite(1'b1, 32'h0);
    doRead(curSetup, 24'h111111, 0, "R2 switch cleared", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule